// File: doc/BRIEF.md
# Run-Length Coded Macroblock Output Sequencer

This block turns one macroblock of quantized transform coefficients into a fixed-cadence byte stream. The coefficients are written first: six 8x8 sub-blocks, each already in zig-zag order. A start pulse then captures the header fields and begins emission. Every byte on the output bus carries a 4-bit type tag and a strobe that a downstream multiplexer uses to take the byte.

A macroblock always begins with seven two-cycle header slots. If any sub-block holds a non-zero coefficient, a 32-cycle gap follows. After it, each coded sub-block occupies a 335-cycle window. The window opens with the sub-block number and carries one run/value pair for each non-zero coefficient. A closing pair marks the end of the sub-block, and wait cycles pad the window to its full length. The block then idles on the wait tag with all ones on the bus and holds a done flag until the next start.

Top module: `rlc_out_seq`

## Requirements
- R1: After reset, and whenever idle, the tag is 15 (wait), the bus is 8'hFF and the strobe is low. Done is low after reset. Every wait cycle anywhere in the stream also carries 8'hFF with the strobe low.
- R2: After start, seven header slots follow, each held 2 cycles, in this order. First come the control flags (tag 2, input bits 4 and 7 forced low), then the group number (tag 0, bits 3:0) and the macroblock number (tag 1, bits 5:0). Next come the coded pattern (tag 6), the quant value (tag 3, bits 4:0), the horizontal vector (tag 4, bits 4:0) and the vertical vector (tag 5, bits 4:0). All other bits are low.
- R3: The coded pattern byte has bit 6 set when sub-block 1 holds a non-zero coefficient, through bit 1 for sub-block 6. Bits 7 and 0 are low.
- R4: When the pattern is non-zero, a 32-cycle wait follows the header. Coded sub-blocks follow in ascending order, each opening with tag 7 held 15 cycles with its number 1 to 6 on bits 2:0. Uncoded sub-blocks never appear.
- R5: Each non-zero coefficient at positions 0 to 62 is sent in ascending position order as a run slot (tag 8, 2 cycles), a value slot (tag 9, 2 cycles) and one wait cycle. The run slot gives the number of zero coefficients since the previous emitted position, with bits 7:6 low.
- R6: The last pair of every coded sub-block belongs to position 63. Its run byte has bits 7:6 set and the zero count before position 63 on bits 5:0. Its value byte is the coefficient at position 63, which may be zero.
- R7: Each coded sub-block spans exactly 335 cycles from its first tag-7 cycle. Wait cycles fill the remainder, and a sub-block with all 64 coefficients non-zero gets no padding.
- R8: The strobe is low in the first cycle of every slot and high for the rest of that slot. It is never high on tag 15.
- R9: When the pattern is zero, the vertical vector slot is followed directly by idle, with no 32-cycle wait.
- R10: Done rises in the first idle cycle after the last slot and stays high until the next accepted start, which clears it.
- R11: The header fields are sampled at start. A start pulse or header change during emission has no effect on the stream.
- R12: The write port address is {sub-block index 0..5, position 0..63}, where index 0 is sub-block 1. The most recently written value at an address is the one emitted, and overwriting a non-zero value with zero uncodes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cw_en | input | 1 | Coefficient write enable |
| cw_addr | input | 9 | Coefficient address {sub-block index, zig-zag position} |
| cw_data | input | 8 | Quantized coefficient, two's complement |
| start | input | 1 | Begin emitting the stored macroblock |
| ctl_flags | input | 8 | Control decision flags |
| gob_num | input | 4 | Group number |
| mb_num | input | 6 | Macroblock number |
| quant | input | 5 | Quantizer value |
| mv_h | input | 5 | Horizontal motion vector, two's complement |
| mv_v | input | 5 | Vertical motion vector, two's complement |
| ob_data | output | 8 | Output byte |
| ob_tag | output | 4 | Type tag of the output byte |
| ob_stb | output | 1 | Output strobe |
| done | output | 1 | Macroblock fully emitted |

## Verification
The hardest situations to reach are the two extremes of the sub-block window. One is a sub-block with all 64 coefficients non-zero, where the final pair ends exactly on the 335th cycle and no padding is allowed. The other is a sub-block whose only content is position 63, where the end pair carries a run of 63. The stimulus writes these patterns directly through the coefficient port. It also writes a sparse sub-block that ends in a zero at position 63, so that a zero value byte appears. A second start and changed header inputs arrive mid-stream to show they are ignored, and one address is overwritten with zero to uncode its sub-block.

// File: rtl/rlc_pkg.sv
// Shared types for the run-length output sequencer.
package rlc_pkg;

    // Output type tags; the numeric values are decoded downstream.
    typedef enum logic [3:0] {
        TAG_GOB   = 4'd0,
        TAG_MB    = 4'd1,
        TAG_CTRL  = 4'd2,
        TAG_QUANT = 4'd3,
        TAG_MVH   = 4'd4,
        TAG_MVV   = 4'd5,
        TAG_CBP   = 4'd6,
        TAG_SBNUM = 4'd7,
        TAG_RUN   = 4'd8,
        TAG_COEF  = 4'd9,
        TAG_WAIT  = 4'd15
    } tag_e;

    // Sequencer phases.
    typedef enum logic [2:0] {
        PH_IDLE, PH_HDR, PH_GAP, PH_SBNUM, PH_RUN, PH_COEF, PH_PWAIT, PH_PAD
    } phase_e;

    // Header fields captured at start.
    typedef struct packed {
        logic [7:0] ctl;
        logic [3:0] gob;
        logic [5:0] mb;
        logic [4:0] quant;
        logic [4:0] mvh;
        logic [4:0] mvv;
    } hdr_t;

    localparam logic [7:0] CTL_USED_MASK = 8'h6F;
    localparam int         HDR_SLOTS     = 7;

endpackage

// File: rtl/rlc_coef_store.sv
// Coefficient store for one macroblock.
// Holds SB_N sub-blocks of POS_N coefficients, plus a non-zero map per entry.
// Reset clears the map, so every entry then reads as zero.
// Assumes writes happen only while the sequencer is idle.
module rlc_coef_store #(
    parameter int SB_N  = 6,
    parameter int POS_N = 64,
    parameter int CW    = 8,
    localparam int SBW  = $clog2(SB_N),
    localparam int PW   = $clog2(POS_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SBW+PW-1:0] wr_addr,
    input  logic [CW-1:0]    wr_data,
    input  logic [SBW-1:0]   rd_sb,
    input  logic [PW-1:0]    rd_pos,
    output logic [CW-1:0]    rd_data,
    output logic [POS_N-1:0] nz_row,
    output logic [SB_N-1:0]  coded
);
    logic [CW-1:0]    mem [SB_N*POS_N];
    logic [POS_N-1:0] nz  [SB_N];

    logic [SBW-1:0] wr_sb;
    logic [PW-1:0]  wr_pos;
    logic           wr_ok;
    logic           rd_ok;

    assign wr_sb  = wr_addr[SBW+PW-1:PW];
    assign wr_pos = wr_addr[PW-1:0];
    assign wr_ok  = wr_en && (int'(wr_sb) < SB_N);
    assign rd_ok  = int'(rd_sb) < SB_N;

    // Store coefficient values; no reset needed because the map gates reads.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[int'(wr_sb)*POS_N + int'(wr_pos)] <= wr_data;
    end

    // Track which entries are non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SB_N; s++) nz[s] <= '0;
        end else if (wr_ok) begin
            nz[wr_sb][wr_pos] <= (wr_data != '0);
        end
    end

    // Read port: value of the addressed entry, masked by its map bit.
    always_comb begin
        rd_data = '0;
        nz_row  = '0;
        if (rd_ok) begin
            nz_row = nz[rd_sb];
            if (nz[rd_sb][rd_pos]) rd_data = mem[int'(rd_sb)*POS_N + int'(rd_pos)];
        end
    end

    // One coded flag per sub-block.
    for (genvar g = 0; g < SB_N; g++) begin : g_coded
        assign coded[g] = |nz[g];
    end

endmodule

// File: rtl/rlc_next_nz.sv
// Finds the lowest non-zero position at or above from_pos, excluding the
// last position, which is always sent as the end pair.
// With no hit, hit_pos points at the last position and found is low.
module rlc_next_nz #(
    parameter int POS_N = 64,
    localparam int PW   = $clog2(POS_N)
) (
    input  logic [POS_N-1:0] nz_row,
    input  logic [PW-1:0]    from_pos,
    output logic             found,
    output logic [PW-1:0]    hit_pos
);
    // Descending scan so the lowest qualifying position wins.
    always_comb begin
        found   = 1'b0;
        hit_pos = PW'(POS_N - 1);
        for (int p = POS_N - 2; p >= 0; p--) begin
            if (nz_row[p] && (p >= int'(from_pos))) begin
                found   = 1'b1;
                hit_pos = PW'(p);
            end
        end
    end

endmodule

// File: rtl/rlc_emit_fsm.sv
// Output sequencer. It walks the header slots, the gap, and each coded
// sub-block window, and drives tag, byte and strobe as a Moore function of
// its state. It assumes the store stays untouched while it is running.
module rlc_emit_fsm
    import rlc_pkg::*;
#(
    parameter int SB_N      = 6,
    parameter int POS_N     = 64,
    parameter int CW        = 8,
    parameter int HDR_HOLD  = 2,
    parameter int GAP_LEN   = 32,
    parameter int SBNUM_LEN = 15,
    parameter int RUN_HOLD  = 2,
    parameter int COEF_HOLD = 2,
    parameter int PAIR_GAP  = 1,
    parameter int SB_SLOT   = 335,
    localparam int SBW      = $clog2(SB_N),
    localparam int PW       = $clog2(POS_N),
    localparam int CNTW     = $clog2(SB_SLOT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  hdr_t            hdr_in,
    input  logic [SB_N-1:0] coded,
    input  logic            nz_found,
    input  logic [PW-1:0]   nz_pos,
    input  logic [CW-1:0]   nz_val,
    output logic [SBW-1:0]  cur_sb,
    output logic [PW-1:0]   search_pos,
    output logic [CW-1:0]   ob_data,
    output logic [3:0]      ob_tag,
    output logic            ob_stb,
    output logic            done
);
    phase_e          phase;
    logic [CNTW-1:0] cnt;
    logic [CNTW-1:0] sb_time;
    logic [2:0]      hdr_idx;
    hdr_t            hdr_q;
    logic [SB_N-1:0] cbp_q;
    logic [SBW-1:0]  sb_q;
    logic [PW-1:0]   pos_q;
    logic [PW-1:0]   pair_run;
    logic [CW-1:0]   pair_val;
    logic            pair_eob;
    logic            done_q;

    logic [SBW-1:0]  first_sb;
    logic [SBW-1:0]  next_sb;
    logic            has_next;
    logic [7:0]      cbp_byte;
    logic            slot_end;
    logic            win_end;

    assign cur_sb     = sb_q;
    assign search_pos = pos_q;
    assign win_end    = (sb_time == CNTW'(SB_SLOT - 1));

    // Lowest coded sub-block overall and the lowest one after the current.
    always_comb begin
        first_sb = '0;
        next_sb  = '0;
        has_next = 1'b0;
        for (int i = SB_N - 1; i >= 0; i--) begin
            if (cbp_q[i]) first_sb = SBW'(i);
            if (cbp_q[i] && (i > int'(sb_q))) begin
                next_sb  = SBW'(i);
                has_next = 1'b1;
            end
        end
    end

    // Coded pattern byte: sub-block 1 on bit 6 down to sub-block 6 on bit 1.
    always_comb begin
        cbp_byte = '0;
        for (int i = 0; i < SB_N; i++) cbp_byte[6 - i] = cbp_q[i];
    end

    // Last cycle of the current fixed-length slot.
    always_comb begin
        case (phase)
            PH_HDR:   slot_end = (cnt == CNTW'(HDR_HOLD - 1));
            PH_GAP:   slot_end = (cnt == CNTW'(GAP_LEN - 1));
            PH_SBNUM: slot_end = (cnt == CNTW'(SBNUM_LEN - 1));
            PH_RUN:   slot_end = (cnt == CNTW'(RUN_HOLD - 1));
            PH_COEF:  slot_end = (cnt == CNTW'(COEF_HOLD - 1));
            PH_PWAIT: slot_end = (cnt == CNTW'(PAIR_GAP - 1));
            default:  slot_end = 1'b1;
        endcase
    end

    // State advance: phases, counters, pair capture, done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            sb_time  <= '0;
            hdr_idx  <= '0;
            hdr_q    <= '0;
            cbp_q    <= '0;
            sb_q     <= '0;
            pos_q    <= '0;
            pair_run <= '0;
            pair_val <= '0;
            pair_eob <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            cnt     <= slot_end ? '0 : cnt + 1'b1;
            sb_time <= sb_time + 1'b1;
            case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) begin
                        hdr_q   <= hdr_in;
                        cbp_q   <= coded;
                        done_q  <= 1'b0;
                        hdr_idx <= '0;
                        phase   <= PH_HDR;
                    end
                end
                PH_HDR: if (slot_end) begin
                    if (hdr_idx == 3'(HDR_SLOTS - 1)) begin
                        if (cbp_q != '0) begin
                            phase <= PH_GAP;
                        end else begin
                            phase  <= PH_IDLE;
                            done_q <= 1'b1;
                        end
                    end else begin
                        hdr_idx <= hdr_idx + 1'b1;
                    end
                end
                PH_GAP: if (slot_end) begin
                    phase   <= PH_SBNUM;
                    sb_q    <= first_sb;
                    sb_time <= '0;
                    pos_q   <= '0;
                end
                PH_SBNUM, PH_PWAIT: begin
                    if (slot_end && (phase == PH_SBNUM || !pair_eob)) begin
                        phase    <= PH_RUN;
                        pair_eob <= !nz_found;
                        pair_run <= nz_pos - pos_q;
                        pair_val <= nz_val;
                        pos_q    <= nz_pos + 1'b1;
                    end else if (slot_end && !win_end) begin
                        phase <= PH_PAD;
                    end else if (slot_end) begin
                        if (has_next) begin
                            phase   <= PH_SBNUM;
                            sb_q    <= next_sb;
                            sb_time <= '0;
                            pos_q   <= '0;
                        end else begin
                            phase  <= PH_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                PH_RUN:  if (slot_end) phase <= PH_COEF;
                PH_COEF: if (slot_end) phase <= PH_PWAIT;
                PH_PAD: begin
                    cnt <= '0;
                    if (win_end) begin
                        if (has_next) begin
                            phase   <= PH_SBNUM;
                            sb_q    <= next_sb;
                            sb_time <= '0;
                            pos_q   <= '0;
                        end else begin
                            phase  <= PH_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Output formatting from the current state.
    always_comb begin
        ob_tag  = TAG_WAIT;
        ob_data = '1;
        case (phase)
            PH_HDR: begin
                case (hdr_idx)
                    3'd0: begin ob_tag = TAG_CTRL;  ob_data = hdr_q.ctl & CTL_USED_MASK; end
                    3'd1: begin ob_tag = TAG_GOB;   ob_data = CW'(hdr_q.gob);   end
                    3'd2: begin ob_tag = TAG_MB;    ob_data = CW'(hdr_q.mb);    end
                    3'd3: begin ob_tag = TAG_CBP;   ob_data = cbp_byte;         end
                    3'd4: begin ob_tag = TAG_QUANT; ob_data = CW'(hdr_q.quant); end
                    3'd5: begin ob_tag = TAG_MVH;   ob_data = CW'(hdr_q.mvh);   end
                    default: begin ob_tag = TAG_MVV; ob_data = CW'(hdr_q.mvv);  end
                endcase
            end
            PH_SBNUM: begin
                ob_tag  = TAG_SBNUM;
                ob_data = CW'(sb_q) + CW'(1);
            end
            PH_RUN: begin
                ob_tag  = TAG_RUN;
                ob_data = CW'(pair_run);
                ob_data[CW-1:CW-2] = {2{pair_eob}};
            end
            PH_COEF: begin
                ob_tag  = TAG_COEF;
                ob_data = pair_val;
            end
            default: ;
        endcase
        ob_stb = (ob_tag != TAG_WAIT) && (cnt != '0);
    end

    assign done = done_q;

endmodule

// File: rtl/rlc_out_seq.sv
// Top level of the run-length output sequencer: coefficient store,
// next-non-zero finder and emission state machine.
// Assumes cw_en stays low from start until done.
module rlc_out_seq
    import rlc_pkg::*;
#(
    parameter int SB_N  = 6,
    parameter int POS_N = 64,
    parameter int CW    = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  cw_en,
    input  logic [$clog2(SB_N)+$clog2(POS_N)-1:0] cw_addr,
    input  logic [CW-1:0]                         cw_data,
    input  logic                                  start,
    input  logic [7:0]                            ctl_flags,
    input  logic [3:0]                            gob_num,
    input  logic [5:0]                            mb_num,
    input  logic [4:0]                            quant,
    input  logic [4:0]                            mv_h,
    input  logic [4:0]                            mv_v,
    output logic [CW-1:0]                         ob_data,
    output logic [3:0]                            ob_tag,
    output logic                                  ob_stb,
    output logic                                  done
);
    localparam int SBW = $clog2(SB_N);
    localparam int PW  = $clog2(POS_N);

    hdr_t             hdr_in;
    logic [SBW-1:0]   cur_sb;
    logic [PW-1:0]    search_pos;
    logic [PW-1:0]    nz_pos;
    logic             nz_found;
    logic [CW-1:0]    nz_val;
    logic [POS_N-1:0] nz_row;
    logic [SB_N-1:0]  coded;

    assign hdr_in = '{ctl: ctl_flags, gob: gob_num, mb: mb_num,
                      quant: quant, mvh: mv_h, mvv: mv_v};

    rlc_coef_store #(.SB_N(SB_N), .POS_N(POS_N), .CW(CW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cw_en),
        .wr_addr (cw_addr),
        .wr_data (cw_data),
        .rd_sb   (cur_sb),
        .rd_pos  (nz_pos),
        .rd_data (nz_val),
        .nz_row  (nz_row),
        .coded   (coded)
    );

    rlc_next_nz #(.POS_N(POS_N)) u_find (
        .nz_row   (nz_row),
        .from_pos (search_pos),
        .found    (nz_found),
        .hit_pos  (nz_pos)
    );

    rlc_emit_fsm #(.SB_N(SB_N), .POS_N(POS_N), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .hdr_in     (hdr_in),
        .coded      (coded),
        .nz_found   (nz_found),
        .nz_pos     (nz_pos),
        .nz_val     (nz_val),
        .cur_sb     (cur_sb),
        .search_pos (search_pos),
        .ob_data    (ob_data),
        .ob_tag     (ob_tag),
        .ob_stb     (ob_stb),
        .done       (done)
    );

endmodule

// File: rtl/rlc_out_seq_chk.sv
// Protocol checker for the output side of rlc_out_seq; attached by bind.
module rlc_out_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ob_data,
    input logic [3:0] ob_tag,
    input logic       ob_stb,
    input logic       done
);
    AST_WAIT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_tag == 4'd15) |-> (ob_data == 8'hFF && !ob_stb));            // R1
    AST_TAG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_tag <= 4'd9) || (ob_tag == 4'd15));                           // R1
    AST_HDR_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_tag <= 4'd6 && ob_tag != $past(ob_tag)) |=> $stable(ob_tag)); // R2
    AST_CBP_EDGES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_tag == 4'd6) |-> (ob_data[7] == 1'b0 && ob_data[0] == 1'b0)); // R3
    AST_SBNUM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_tag == 4'd7) |-> (ob_data >= 8'd1 && ob_data <= 8'd6));      // R4
    AST_RUN_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_tag == 4'd8) |-> (ob_data[7] == ob_data[6]));                 // R6
    AST_STB_FIRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_tag != $past(ob_tag)) |-> !ob_stb);                           // R8
    AST_STB_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ob_stb |-> ($stable(ob_tag) && $stable(ob_data)));                // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ob_tag == 4'd15));                                      // R10
endmodule

bind rlc_out_seq rlc_out_seq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ob_data (ob_data),
    .ob_tag  (ob_tag),
    .ob_stb  (ob_stb),
    .done    (done)
);

// File: tb/sim_rlc_out_seq.sv
// Scoreboard bench: a driver builds the expected per-cycle stream, a monitor compares.
module sim_rlc_out_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cw_en = 1'b0;
    logic [8:0] cw_addr = '0;
    logic [7:0] cw_data = '0;
    logic       start = 1'b0;
    logic [7:0] ctl_flags = '0;
    logic [3:0] gob_num = '0;
    logic [5:0] mb_num = '0;
    logic [4:0] quant = '0;
    logic [4:0] mv_h = '0;
    logic [4:0] mv_v = '0;
    logic [7:0] ob_data;
    logic [3:0] ob_tag;
    logic       ob_stb;
    logic       done;

    int tests = 0;
    int fails = 0;
    logic armed = 1'b0;

    typedef struct {
        logic [3:0] tag;
        logic [7:0] data;
        logic       stb;
        logic       dn;
        string      req;
    } item_t;
    item_t exp_q[$];

    logic [7:0] coef [6][64];

    always #5 clk = ~clk;

    rlc_out_seq u0 (
        .clk(clk), .rst_n(rst_n), .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data),
        .start(start), .ctl_flags(ctl_flags), .gob_num(gob_num), .mb_num(mb_num),
        .quant(quant), .mv_h(mv_h), .mv_v(mv_v),
        .ob_data(ob_data), .ob_tag(ob_tag), .ob_stb(ob_stb), .done(done)
    );

    task automatic check(string req, logic [3:0] t, logic [7:0] d, logic s, logic dn);
        tests++;
        if (ob_tag !== t || ob_data !== d || ob_stb !== s || done !== dn) begin
            fails++;
            $display("FAIL %s: got tag=%0d data=%02h stb=%0b done=%0b, expected tag=%0d data=%02h stb=%0b done=%0b",
                     req, ob_tag, ob_data, ob_stb, done, t, d, s, dn);
        end
    endtask

    // Monitor: pop one expected cycle per negedge while armed.
    always @(negedge clk) begin
        if (armed && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check(it.req, it.tag, it.data, it.stb, it.dn);
        end
    end

    // Push n cycles of one slot; strobe low on the first (R8).
    task automatic push(logic [3:0] t, logic [7:0] d, int n, string req);
        for (int i = 0; i < n; i++)
            exp_q.push_back('{t, d, (i != 0) && (t != 4'd15), 1'b0, req});
    endtask

    task automatic wr(int sb, int pos, logic [7:0] v);
        @(negedge clk);
        cw_en   <= 1'b1;
        cw_addr <= 9'((sb << 6) | pos);
        cw_data <= v;
        coef[sb][pos] = v;
        @(negedge clk);
        cw_en <= 1'b0;
    endtask

    task automatic clear_all();
        for (int s = 0; s < 6; s++)
            for (int p = 0; p < 64; p++) wr(s, p, 8'h00);
    endtask

    // Build the expected stream from the requirements.
    task automatic build_expect();
        logic [7:0] cbp;
        cbp = '0;
        for (int s = 0; s < 6; s++)
            for (int p = 0; p < 64; p++) if (coef[s][p] != 0) cbp[6 - s] = 1'b1;
        push(4'd2, ctl_flags & 8'h6F, 2, "R2 ctrl");
        push(4'd0, {4'b0, gob_num}, 2, "R2 gob");
        push(4'd1, {2'b0, mb_num}, 2, "R2 mb");
        push(4'd6, cbp, 2, "R3 cbp");
        push(4'd3, {3'b0, quant}, 2, "R2 quant");
        push(4'd4, {3'b0, mv_h}, 2, "R2 mvh");
        push(4'd5, {3'b0, mv_v}, 2, "R2 mvv");
        if (cbp != 0) begin
            push(4'd15, 8'hFF, 32, "R4 gap");
            for (int s = 0; s < 6; s++) begin
                if (cbp[6 - s]) begin
                    int t, last;
                    push(4'd7, 8'(s + 1), 15, "R4 sbnum");
                    t = 15; last = 0;
                    for (int p = 0; p < 63; p++) begin
                        if (coef[s][p] != 0) begin
                            push(4'd8, 8'(p - last), 2, "R5 run");
                            push(4'd9, coef[s][p], 2, "R5 value");
                            push(4'd15, 8'hFF, 1, "R5 pair wait");
                            t += 5; last = p + 1;
                        end
                    end
                    push(4'd8, {2'b11, 6'(63 - last)}, 2, "R6 end run");
                    push(4'd9, coef[s][63], 2, "R6 end value");
                    push(4'd15, 8'hFF, 1, "R6 pair wait");
                    t += 5;
                    push(4'd15, 8'hFF, 335 - t, "R7 pad");
                end
            end
        end
        exp_q.push_back('{4'd15, 8'hFF, 1'b0, 1'b1, "R9 R10 done idle"});
    endtask

    // Driver: start, optional mid-stream poke (R11), wait for queue to drain.
    task automatic run_mb(int poke);
        build_expect();
        @(negedge clk);
        start <= 1'b1;
        armed <= 1'b1;
        @(negedge clk);
        start <= 1'b0;
        if (poke > 0) begin
            repeat (poke) @(negedge clk);
            start     <= 1'b1;
            ctl_flags <= ~ctl_flags;
            gob_num   <= ~gob_num;
            quant     <= ~quant;
            @(negedge clk);
            start <= 1'b0;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        armed <= 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int s = 0; s < 6; s++) for (int p = 0; p < 64; p++) coef[s][p] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        check("R1 reset idle", 4'd15, 8'hFF, 1'b0, 1'b0);

        // Empty macroblock, unused control bits set (R2, R9, R10).
        ctl_flags = 8'hFF; gob_num = 4'hA; mb_num = 6'h2D;
        quant = 5'h13; mv_h = 5'h1C; mv_v = 5'h07;
        run_mb(0);
        repeat (3) @(negedge clk);
        check("R10 done held", 4'd15, 8'hFF, 1'b0, 1'b1);

        // Sparse: sub-block 1 ends with zero at 63, sub-block 4 only at 63,
        // sub-block 3 overwritten back to zero (R6, R12), mid-run start (R11).
        wr(0, 0, 8'd12); wr(0, 5, 8'hFD);
        wr(3, 63, 8'd7);
        wr(2, 10, 8'd9); wr(2, 10, 8'h00);
        ctl_flags = 8'h25; gob_num = 4'h3; mb_num = 6'h01;
        quant = 5'h02; mv_h = 5'h11; mv_v = 5'h0F;
        run_mb(100);

        // Dense sub-block 6 (no padding, R7) and sub-block 2 with value at 62.
        clear_all();
        for (int p = 0; p < 64; p++) wr(5, p, (p % 2 == 0) ? 8'(p + 1) : 8'(-(p + 1)));
        wr(1, 62, 8'd1);
        ctl_flags = 8'h4A; gob_num = 4'hC; mb_num = 6'h21;
        quant = 5'h1F; mv_h = 5'h00; mv_v = 5'h19;
        run_mb(0);

        @(negedge clk);
        check("R1 idle after run", 4'd15, 8'hFF, 1'b0, 1'b1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule